// File: doc/BRIEF.md
# Serial EEPROM Page Buffer and Write Engine

This block sits behind the serial bus front-end of a small byte-wide non-volatile memory. The front-end hands it a word address, then a stream of data bytes, then a Stop. The bytes land in a 16-entry page buffer indexed by the low four bits of an address pointer. That pointer advances within the current 16-byte page and wraps to the start of the page rather than moving into the next one. Bytes stay in the buffer until Stop. Stop then opens an internal write cycle of fixed length, during which the buffered bytes go to a 128 x 8 storage array.

A write-protect level can lock the upper half of the array (addresses 40h to 7Fh). A write aimed at a locked page is accepted and still occupies the full write cycle, but it does not change the array. While the cycle runs, the block raises busy so that the front-end stops acknowledging. It ignores every input until busy falls.

The commit runs during the first 16 cycles of the write cycle. Slot k is handled in cycle k of busy, counting from 0, so slots are visited in ascending order. Only slots that received a byte since the last address load are written. `WCYCLE` must be at least 16.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy is low and the array write strobe is low.
- R2: Received data bytes are held in the page buffer. No array write takes place before Stop.
- R3: After each received byte, only the low four bits of the address pointer advance, and they wrap from Fh to 0h. The upper three bits stay constant, so a page write never leaves its 16-byte page.
- R4: If more than 16 bytes arrive before Stop, the pointer wraps and the later bytes replace the earlier bytes in the same slots. Each slot is written once, holding its last byte.
- R5: Only slots that received a byte since the most recent address load are written. An address load discards bytes buffered before it.
- R6: A Stop with at least one buffered byte raises busy from the next clock edge. Busy then stays high for exactly `WCYCLE` cycles, and every array write happens inside that window.
- R7: If the write-protect input is high when Stop is sampled and the page lies in 40h to 7Fh, no array write takes place. Busy still lasts the full `WCYCLE` cycles.
- R8: If the write-protect input is high, pages in 00h to 3Fh are still written normally.
- R9: A Stop with no buffered byte starts no write cycle. The loaded address is kept, and later bytes are stored starting from it.
- R10: While busy is high, address loads, data strobes and Stop have no effect on the array or on the address pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load `addr_in` into the pointer and clear the buffered-slot mask |
| addr_in | input | 7 | Word address |
| byte_stb | input | 1 | A data byte is present on `byte_in` |
| byte_in | input | 8 | Data byte |
| stop | input | 1 | Stop seen on the bus |
| wp | input | 1 | Write-protect level; high locks 40h to 7Fh |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume that the front-end pulses `addr_load`, `byte_stb` and `stop` for one cycle each and never raises two of them in the same cycle. The directed tasks respect this: each strobe is raised at a falling edge and dropped at the next one. Input activity during busy is generated deliberately, to show that it is ignored. The bench judges the array contents through a shadow copy built only from observed `mem_we` cycles, and it measures busy by counting cycles at falling edges.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  parameter int WCYCLE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WCYCLE + 1);

  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0]   valid;
  logic [CNT_W-1:0]  cnt;
  logic              prot;
  logic [DATA_W-1:0] pbuf [PAGE];

  wire [PAGE_W-1:0] slot   = cnt[PAGE_W-1:0];
  wire              in_win = cnt < CNT_W'(PAGE);

  always_ff @(posedge clk) begin
    if (!busy && !addr_load && byte_stb)
      pbuf[ptr[PAGE_W-1:0]] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      valid <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      prot  <= 1'b0;
    end else if (busy) begin
      if (cnt == CNT_W'(WCYCLE - 1)) begin
        busy  <= 1'b0;
        cnt   <= '0;
        valid <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (addr_load) begin
      ptr   <= addr_in;
      valid <= '0;
    end else if (byte_stb) begin
      valid[ptr[PAGE_W-1:0]] <= 1'b1;
      ptr[PAGE_W-1:0]        <= ptr[PAGE_W-1:0] + 1'b1;
    end else if (stop && |valid) begin
      busy <= 1'b1;
      cnt  <= '0;
      prot <= wp && ptr[ADDR_W-1];
    end
  end

  assign mem_we    = busy && in_win && valid[slot] && !prot;
  assign mem_addr  = {ptr[ADDR_W-1:PAGE_W], slot};
  assign mem_wdata = pbuf[slot];

  // R6
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));
  // R9
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && valid == '0 && !byte_stb && !addr_load) |=> !busy);
  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]));
  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr));
  // R7
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prot) |-> !mem_we);
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
  localparam int CLK_P  = 10;
  localparam int WCYCLE = 32;

  logic clk = 0, rst_n = 0;
  logic addr_load = 0, byte_stb = 0, stop = 0, wp = 0;
  logic [6:0] addr_in = 0;
  logic [7:0] byte_in = 0;
  logic busy, mem_we;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata;

  int checks = 0, errors = 0;
  int wr_cnt = 0, busy_cyc = 0;
  logic [7:0] shadow [128];

  always #(CLK_P/2) clk = ~clk;

  eeprom_page_writer #(.WCYCLE(WCYCLE)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .stop(stop), .wp(wp),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(negedge clk) begin
    if (mem_we) begin
      shadow[mem_addr] = mem_wdata;
      wr_cnt++;
    end
    if (busy) busy_cyc++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [6:0] a);
    @(negedge clk); addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); byte_stb = 1; byte_in = d;
    @(negedge clk); byte_stb = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_counts();
    wr_cnt = 0; busy_cyc = 0;
  endtask

  task automatic t_reset();
    check(busy == 0, "R1 busy", busy, 0);
    check(mem_we == 0, "R1 mem_we", mem_we, 0);
  endtask

  task automatic t_single();
    clear_counts();
    do_load(7'h05); do_byte(8'hA5);
    check(wr_cnt == 0, "R2 no write before stop", wr_cnt, 0);
    do_stop();
    check(busy == 1, "R6 busy after stop", busy, 1);
    wait_idle();
    check(shadow[7'h05] == 8'hA5, "R2 byte stored", shadow[7'h05], 8'hA5);
    check(wr_cnt == 1, "R5 one write", wr_cnt, 1);
    check(busy_cyc == WCYCLE, "R6 busy length", busy_cyc, WCYCLE);
  endtask

  task automatic t_page_wrap();
    clear_counts();
    do_load(7'h13);
    for (int i = 0; i < 16; i++) do_byte(8'h80 + 8'(i));
    check(wr_cnt == 0, "R2 page held", wr_cnt, 0);
    do_stop(); wait_idle();
    check(wr_cnt == 16, "R3 write count", wr_cnt, 16);
    for (int i = 0; i < 16; i++) begin
      logic [6:0] a;
      a = {3'h1, 4'(3 + i)};
      check(shadow[a] == 8'h80 + 8'(i), "R3 wrap address", shadow[a], 8'h80 + i);
    end
    check(shadow[7'h20] == 8'h00, "R3 next page untouched", shadow[7'h20], 0);
  endtask

  task automatic t_rollover();
    clear_counts();
    do_load(7'h20);
    for (int i = 0; i < 18; i++) do_byte(8'h40 + 8'(i));
    do_stop(); wait_idle();
    check(wr_cnt == 16, "R4 write count", wr_cnt, 16);
    check(shadow[7'h20] == 8'h50, "R4 slot0 overwritten", shadow[7'h20], 8'h50);
    check(shadow[7'h21] == 8'h51, "R4 slot1 overwritten", shadow[7'h21], 8'h51);
    check(shadow[7'h22] == 8'h42, "R4 slot2 kept", shadow[7'h22], 8'h42);
  endtask

  task automatic t_protect();
    clear_counts();
    wp = 1;
    do_load(7'h45); do_byte(8'h3C); do_byte(8'h3D);
    do_stop(); wait_idle();
    check(wr_cnt == 0, "R7 no write", wr_cnt, 0);
    check(busy_cyc == WCYCLE, "R7 busy length", busy_cyc, WCYCLE);
    clear_counts();
    do_load(7'h30); do_byte(8'hC3);
    do_stop(); wait_idle();
    check(shadow[7'h30] == 8'hC3, "R8 lower half written", shadow[7'h30], 8'hC3);
    check(wr_cnt == 1, "R8 write count", wr_cnt, 1);
    wp = 0;
  endtask

  task automatic t_mask();
    clear_counts();
    do_load(7'h64); do_byte(8'h99);
    do_load(7'h60);
    for (int i = 0; i < 3; i++) do_byte(8'h10 + 8'(i));
    do_stop(); wait_idle();
    check(wr_cnt == 3, "R5 only received slots", wr_cnt, 3);
    check(shadow[7'h64] == 8'h00, "R5 discarded byte", shadow[7'h64], 0);
    check(shadow[7'h62] == 8'h12, "R5 last slot", shadow[7'h62], 8'h12);
  endtask

  task automatic t_empty_stop();
    clear_counts();
    do_load(7'h50); do_stop();
    repeat (3) @(negedge clk);
    check(busy_cyc == 0, "R9 no cycle", busy_cyc, 0);
    do_byte(8'h5A); do_stop(); wait_idle();
    check(shadow[7'h50] == 8'h5A, "R9 pointer kept", shadow[7'h50], 8'h5A);
  endtask

  task automatic t_busy_ignore();
    clear_counts();
    do_load(7'h08); do_byte(8'h11); do_stop();
    do_load(7'h70); do_byte(8'hEE); do_stop();
    wait_idle();
    check(wr_cnt == 1, "R10 write count", wr_cnt, 1);
    check(shadow[7'h70] == 8'h00, "R10 no stray write", shadow[7'h70], 0);
    do_byte(8'h77); do_stop(); wait_idle();
    check(shadow[7'h09] == 8'h77, "R10 pointer unchanged", shadow[7'h09], 8'h77);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single();
    t_page_wrap();
    t_rollover();
    t_protect();
    t_mask();
    t_empty_stop();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule